// File: doc/BRIEF.md
# Pin I/O Controller with Event Interrupts

This block is a register-mapped general-purpose pin controller for up to 12 pins (or 8 in a smaller build). Software reads and writes 32-bit words through a flat interface: a word address, a write enable, write data and combinational read data. The block holds an output value and a direction bit for each pin, and it returns the synchronized level seen on each input.

Each pin has its own event detector. The detector can fire on a rising edge, a falling edge, either edge, a high level or a low level. Detected events are latched into a per-pin status bit. Software clears status bits by writing ones. A per-pin mask, with separate set and clear words, gates which latched events reach the single interrupt output.

A soft-reset word returns every configuration register to its power-on value. Writing 1 to it and then 0 does this.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After rst_ni is released, every readable word is 0 except the mask, which reads all ones across the pin count. pin_oe_o and irq_o are 0.
- R2: Word offsets are as follows: enable 0x0, pending 0x1, raw-latched 0x2, clear 0x3, mask-set 0x4, mask-clear 0x5, out 0x6, in 0x7, direction 0x8, mode-lo 0x9, mode-hi 0xA, pin-select 0xE and soft-reset 0xF. Offsets 0xB to 0xD read 0. Bits at or above NPINS read 0 and ignore writes.
- R3: pin_oe_o equals the direction word, where 1 means output. pin_o equals the out word.
- R4: The in word returns pin_i after a two-flop synchronizer.
- R5: Pin k has a 3-bit mode at bits [4m+2:4m], with m = k mod 8. Pins 0 to 7 use mode-lo and pins 8 and up use mode-hi. The fourth bit of each nibble reads 0.
- R6: Mode 1 latches on a rising edge, mode 0 on a falling edge and mode 4 on either edge. An edge is a change between the current and the previous synchronized sample.
- R7: Mode 2 latches while the pin is low and mode 3 latches while it is high. The bit is set on every such cycle, so clearing it while the level holds leaves it set.
- R8: Mode codes 5 to 7 never latch. A pin whose enable bit is 0 never latches.
- R9: Writing 1 to a bit of the clear word clears that latched bit. Writing 0 to a bit leaves it unchanged.
- R10: Writing 1 to mask-set masks a pin and writing 1 to mask-clear unmasks it. Both offsets read back the mask. The pending word returns latched bits that are not masked, while the raw-latched word returns all latched bits. irq_o is the OR of the pending bits.
- R11: While bit 0 of the soft-reset word is 1, every other register is held at its R1 value. Writing 0 to that bit releases them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Word address |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| pin_i | input | NPINS | Pad input levels |
| pin_o | output | NPINS | Output values to pads |
| pin_oe_o | output | NPINS | Output enables to pads |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions assume that a write to the soft-reset word and a write to any other word never happen in the same cycle. The single address bus guarantees this. They also assume that pin_i is low around the reset release, so that the synchronizer does not report a spurious edge. The stimulus changes pin_i only on falling clock edges and waits at least four cycles before it reads any status. It holds all pins low through reset. Before each event test, it clears stale latched bits only after the level conditions have settled.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [2:0] {
    MD_FALL = 3'd0,
    MD_RISE = 3'd1,
    MD_LOW  = 3'd2,
    MD_HIGH = 3'd3,
    MD_BOTH = 3'd4
  } det_mode_e;

  localparam logic [3:0] OFS_IEN  = 4'h0;
  localparam logic [3:0] OFS_PEND = 4'h1;
  localparam logic [3:0] OFS_RAW  = 4'h2;
  localparam logic [3:0] OFS_CLR  = 4'h3;
  localparam logic [3:0] OFS_MSET = 4'h4;
  localparam logic [3:0] OFS_MCLR = 4'h5;
  localparam logic [3:0] OFS_OUT  = 4'h6;
  localparam logic [3:0] OFS_IN   = 4'h7;
  localparam logic [3:0] OFS_DIR  = 4'h8;
  localparam logic [3:0] OFS_MD0  = 4'h9;
  localparam logic [3:0] OFS_MD1  = 4'hA;
  localparam logic [3:0] OFS_SEL  = 4'hE;
  localparam logic [3:0] OFS_SRST = 4'hF;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign cur_o  = s2_q;
  assign prev_o = s3_q;
endmodule

// File: rtl/gpio_evt_det.sv
module gpio_evt_det
  import gpio_irq_pkg::*;
(
  input  logic [2:0] mode_i,
  input  logic       en_i,
  input  logic       cur_i,
  input  logic       prev_i,
  output logic       hit_o
);
  logic raw;

  always_comb begin
    case (mode_i)
      MD_FALL: raw = prev_i & ~cur_i;
      MD_RISE: raw = ~prev_i & cur_i;
      MD_LOW:  raw = ~cur_i;
      MD_HIGH: raw = cur_i;
      MD_BOTH: raw = prev_i ^ cur_i;
      default: raw = 1'b0;
    endcase
  end

  assign hit_o = en_i & raw;
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       addr_i,
  input  logic             we_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] pin_o,
  output logic [NPINS-1:0] pin_oe_o,
  output logic             irq_o
);
  localparam logic [NPINS-1:0] ALL_ONES = '1;
  localparam int PAD = 32 - NPINS;

  logic [NPINS-1:0] ien_q, mask_q, out_q, dir_q, sel_q, stat_q;
  logic             srst_q;
  logic [2:0]       mode_q [NPINS];
  logic [NPINS-1:0] cur, prev, hit;
  logic [NPINS-1:0] wbits;
  logic             wr_ok;
  logic [31:0]      md_rd [2];

  assign wbits = wdata_i[NPINS-1:0];
  assign wr_ok = we_i & ~srst_q;

  gpio_sync #(.W(NPINS)) sync_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .cur_o(cur), .prev_o(prev)
  );

  for (genvar k = 0; k < NPINS; k++) begin : g_pin
    localparam int MSEL = k / 8;
    localparam int LO   = 4 * (k % 8);
    localparam logic [3:0] MOFS = (MSEL == 0) ? OFS_MD0 : OFS_MD1;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          mode_q[k] <= '0;
      else if (srst_q)                      mode_q[k] <= '0;
      else if (wr_ok && addr_i == MOFS)     mode_q[k] <= wdata_i[LO +: 3];
    end

    gpio_evt_det det_i (
      .mode_i(mode_q[k]), .en_i(ien_q[k]), .cur_i(cur[k]),
      .prev_i(prev[k]), .hit_o(hit[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q <= '0; mask_q <= ALL_ONES; out_q <= '0;
      dir_q <= '0; sel_q <= '0; stat_q <= '0; srst_q <= 1'b0;
    end else begin
      if (we_i && addr_i == OFS_SRST) srst_q <= wdata_i[0];
      if (srst_q) begin
        ien_q <= '0; mask_q <= ALL_ONES; out_q <= '0;
        dir_q <= '0; sel_q <= '0; stat_q <= '0;
      end else begin
        if (wr_ok && addr_i == OFS_IEN)  ien_q  <= wbits;
        if (wr_ok && addr_i == OFS_OUT)  out_q  <= wbits;
        if (wr_ok && addr_i == OFS_DIR)  dir_q  <= wbits;
        if (wr_ok && addr_i == OFS_SEL)  sel_q  <= wbits;
        if (wr_ok && addr_i == OFS_MSET) mask_q <= mask_q | wbits;
        if (wr_ok && addr_i == OFS_MCLR) mask_q <= mask_q & ~wbits;
        // set wins over clear: a live condition re-latches
        if (wr_ok && addr_i == OFS_CLR) stat_q <= (stat_q & ~wbits) | hit;
        else                             stat_q <= stat_q | hit;
      end
    end
  end

  always_comb begin
    md_rd[0] = '0;
    md_rd[1] = '0;
    for (int k = 0; k < NPINS; k++) md_rd[k / 8][4 * (k % 8) +: 3] = mode_q[k];
  end

  always_comb begin
    case (addr_i)
      OFS_IEN:            rdata_o = {{PAD{1'b0}}, ien_q};
      OFS_PEND:           rdata_o = {{PAD{1'b0}}, stat_q & ~mask_q};
      OFS_RAW:            rdata_o = {{PAD{1'b0}}, stat_q};
      OFS_MSET, OFS_MCLR: rdata_o = {{PAD{1'b0}}, mask_q};
      OFS_OUT:            rdata_o = {{PAD{1'b0}}, out_q};
      OFS_IN:             rdata_o = {{PAD{1'b0}}, cur};
      OFS_DIR:            rdata_o = {{PAD{1'b0}}, dir_q};
      OFS_MD0:            rdata_o = md_rd[0];
      OFS_MD1:            rdata_o = md_rd[1];
      OFS_SEL:            rdata_o = {{PAD{1'b0}}, sel_q};
      OFS_SRST:           rdata_o = {31'd0, srst_q};
      default:            rdata_o = '0;
    endcase
  end

  assign pin_o    = out_q;
  assign pin_oe_o = dir_q;
  assign irq_o    = |(stat_q & ~mask_q);
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             we_i,
  input logic [3:0]       addr_i,
  input logic [31:0]      wdata_i,
  input logic [NPINS-1:0] pin_oe_o,
  input logic             irq_o,
  input logic             srst_q,
  input logic [NPINS-1:0] ien_q,
  input logic [NPINS-1:0] mask_q,
  input logic [NPINS-1:0] stat_q
);
  AST_DIR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(we_i && addr_i == OFS_DIR && !srst_q) |-> pin_oe_o == $past(wdata_i[NPINS-1:0])); // R3

  AST_EN_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_q & ~$past(stat_q) & ~$past(ien_q)) == '0)); // R8

  AST_MSET_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(we_i && addr_i == OFS_MSET && !srst_q)
      |-> ((mask_q & $past(wdata_i[NPINS-1:0])) == $past(wdata_i[NPINS-1:0]))); // R10

  AST_IRQ_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|stat_q)); // R10

  AST_SRST_DEF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(srst_q) |-> (ien_q == '0 && pin_oe_o == '0 && stat_q == '0 && !irq_o)); // R11
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPINS(NPINS)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .pin_oe_o(pin_oe_o), .irq_o(irq_o), .srst_q(srst_q),
  .ien_q(ien_q), .mask_q(mask_q), .stat_q(stat_q)
);

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb_top;
  localparam int NPINS = 12;

  typedef struct packed {
    logic        we;
    logic [3:0]  addr;
    logic [31:0] wdata;
    logic [31:0] expv;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 4'h0, 32'hFFFF_FFFF, 32'h0},
    '{1'b0, 4'h0, 32'h0,         32'h0000_0FFF},
    '{1'b1, 4'h8, 32'hFFFF_F0A5, 32'h0},
    '{1'b0, 4'h8, 32'h0,         32'h0000_00A5},
    '{1'b1, 4'h6, 32'h0000_05A5, 32'h0},
    '{1'b0, 4'h6, 32'h0,         32'h0000_05A5},
    '{1'b1, 4'h9, 32'hFFFF_FFFF, 32'h0},
    '{1'b0, 4'h9, 32'h0,         32'h7777_7777},
    '{1'b1, 4'hA, 32'hFFFF_FFFF, 32'h0},
    '{1'b0, 4'hA, 32'h0,         32'h0000_7777},
    '{1'b1, 4'hE, 32'hFFFF_FFFF, 32'h0},
    '{1'b0, 4'hE, 32'h0,         32'h0000_0FFF},
    '{1'b0, 4'hB, 32'h0,         32'h0},
    '{1'b1, 4'h9, 32'h89AB_CDEF, 32'h0},
    '{1'b0, 4'h9, 32'h0,         32'h0123_4567},
    '{1'b0, 4'hD, 32'h0,         32'h0}
  };

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [3:0]       addr = '0;
  logic             we = 1'b0;
  logic [31:0]      wdata = '0;
  logic [31:0]      rdata;
  logic [NPINS-1:0] pin_in = '0;
  logic [NPINS-1:0] pin_out, pin_oe;
  logic             irq;
  int               errors = 0;
  int               checks = 0;

  always #2 clk = ~clk;

  gpio_irq_ctrl #(.NPINS(NPINS)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pin_in), .pin_o(pin_out), .pin_oe_o(pin_oe), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: got %h exp %h", tag, act, expv);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] expv, input string tag);
    addr = a;
    #1;
    chk(tag, rdata, expv);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait_cyc(3);
    rst_ni = 1'b1;
    wait_cyc(1);

    // R1 reset state
    for (int a = 0; a < 16; a++)
      rd(a[3:0], (a == 4 || a == 5) ? 32'h0000_0FFF : 32'h0, "R1 reset read");
    chk("R1 pin_oe", {20'd0, pin_oe}, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'h0);

    // R2 R5 register table
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].we) wr(VECS[i].addr, VECS[i].wdata);
      else            rd(VECS[i].addr, VECS[i].expv, "R2 R5 table");
    end

    // R3 pad drive
    chk("R3 pin_oe", {20'd0, pin_oe}, 32'h0A5);
    chk("R3 pin_o", {20'd0, pin_out}, 32'h5A5);

    // R11 soft reset
    wr(4'hF, 32'h1);
    wr(4'h0, 32'hFFF);
    wr(4'hF, 32'h0);
    rd(4'h0, 32'h0, "R11 ien");
    rd(4'h8, 32'h0, "R11 dir");
    rd(4'h9, 32'h0, "R11 mode");
    rd(4'h4, 32'hFFF, "R11 mask");
    rd(4'hF, 32'h0, "R11 srst");

    // R4 input sync, R8 ien=0 no latch
    pin_in = 12'h3C3;
    wait_cyc(1);
    rd(4'h7, 32'h0, "R4 in after one clock");
    wait_cyc(3);
    rd(4'h7, 32'h3C3, "R4 in");
    rd(4'h2, 32'h0, "R8 ien off");
    pin_in = '0;
    wait_cyc(4);

    // configure: p0 rise, p1 fall, p2 both, p3 low, p4 high, p5 mode5, p9 rise
    wr(4'h9, 32'h0053_2401);
    wr(4'hA, 32'h0000_0010);
    wr(4'h0, 32'hFFF);
    wait_cyc(4);
    rd(4'h2, 32'h008, "R7 low level latched");
    rd(4'h1, 32'h0, "R10 masked pending");
    chk("R10 irq masked", {31'd0, irq}, 32'h0);
    wr(4'h3, 32'h008);
    wait_cyc(1);
    rd(4'h2, 32'h008, "R7 clear while low");

    pin_in = 12'h008;
    wait_cyc(4);
    wr(4'h3, 32'h008);
    wait_cyc(1);
    rd(4'h2, 32'h0, "R9 clear");

    pin_in = 12'h23D;
    wait_cyc(4);
    rd(4'h2, 32'h215, "R6 R7 R8 rise and high");

    wr(4'h3, 32'h001);
    rd(4'h2, 32'h214, "R9 partial clear");

    wr(4'h5, 32'h201);
    rd(4'h1, 32'h200, "R10 pending");
    rd(4'h5, 32'hDFE, "R10 mask read");
    chk("R10 irq on", {31'd0, irq}, 32'h1);
    wr(4'h4, 32'h200);
    rd(4'h1, 32'h0, "R10 remask pending");
    chk("R10 irq off", {31'd0, irq}, 32'h0);
    rd(4'h2, 32'h214, "R10 raw kept");

    pin_in = 12'h00A;
    wait_cyc(4);
    wr(4'h3, 32'hFFF);
    wait_cyc(1);
    rd(4'h2, 32'h0, "R9 clear all");
    pin_in = 12'h008;
    wait_cyc(4);
    rd(4'h2, 32'h002, "R6 falling");

    wr(4'h0, 32'h0);
    pin_in = 12'h009;
    wait_cyc(4);
    rd(4'h2, 32'h002, "R8 disabled rise");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule